// File: doc/BRIEF.md
# DRAM CBR Refresh Sequencer

This block keeps up to four DRAM banks refreshed with CAS-before-RAS cycles. An interval counter advances once per memory clock while refresh is configured. At the end of each interval a pending request is raised toward the memory arbiter. Once no transaction is in flight, the block drops all four column strobes. Two memory clocks later it drops the row strobes of the enabled banks and holds them for a programmed length. It then releases every strobe on the same edge and keeps `busy_o` high through a programmed precharge gap, so that later accesses stay off the DRAM.

An access aimed at a bank whose enable bit is clear is not carried out. It raises the same pending request, which produces an all-bank refresh. A sleep request runs the identical CAS-then-RAS entry and then freezes the strobes low, which puts the DRAM into self-refresh. A hardware reset is the only way out of that state. A soft reset aborts a normal refresh and drops a pending request, but it leaves the interval counter and self-refresh as they are.

Top module: `dram_refresh_seq`

## Requirements
- R1: The interval counter advances only while `bank_en_i` has at least one bit set and `intv_i` is nonzero; otherwise no periodic refresh occurs.
- R2: With the counter running and `txn_busy_i` low, refresh cycles start exactly every 4*`intv_i` memory clocks. After a hardware reset, the first one starts 4*`intv_i`+1 clocks after reset release.
- R3: `ref_due_o` is high while a request waits. A refresh starts only on a clock edge at which `txn_busy_i` is low, and it starts on the first such edge.
- R4: A refresh drives all four `cas_n_o` bits low first. Exactly two clocks later, `ras_n_o` goes low on the banks whose `bank_en_i` bit is set (`ras_n_o` = ~`bank_en_i`), and the other banks stay high.
- R5: `ras_n_o` stays low for `ras_len_i`+1 clocks. Then all `cas_n_o` and `ras_n_o` bits return high on the same edge.
- R6: After release, `busy_o` and `hold_o` stay high for `pre_len_i` more clocks. `busy_o` is high from the first CAS-low clock to the end of that hold.
- R7: `soft_rst_i` returns a normal refresh to idle and clears a pending request, but it does not disturb the interval counter's phase. A hardware reset clears the counter.
- R8: An access (`acc_req_i`) to a bank whose enable bit is clear raises a pending request and causes a refresh. An access to an enabled bank has no effect.
- R9: While `sleep_req_i` is high and the block is idle with `txn_busy_i` low, the block runs the CAS-then-RAS entry and then holds `cas_n_o` at 0 and `ras_n_o` at ~`bank_en_i` with `self_ref_o` high. Accesses and soft reset do not end this state.
- R10: A request that arrives while a refresh is running is kept. The next refresh starts one clock after the sequencer returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory clock |
| rst_ni | input | 1 | Asynchronous hardware reset, active low |
| soft_rst_i | input | 1 | Synchronous soft reset (counter kept) |
| bank_en_i | input | 4 | Per-bank enable |
| intv_i | input | 8 | Refresh interval, in units of 4 clocks |
| ras_len_i | input | 4 | RAS low length minus one |
| pre_len_i | input | 4 | Precharge hold-off length |
| txn_busy_i | input | 1 | A DRAM transaction is in progress |
| acc_req_i | input | 1 | Access attempt strobe |
| acc_bank_i | input | 2 | Bank targeted by the access |
| sleep_req_i | input | 1 | Enter self-refresh (level) |
| ref_due_o | output | 1 | Refresh request pending |
| busy_o | output | 1 | Refresh or precharge hold in progress |
| hold_o | output | 1 | Precharge hold-off phase |
| self_ref_o | output | 1 | DRAM held in self-refresh |
| cas_n_o | output | 4 | Column strobes, active low |
| ras_n_o | output | 4 | Row strobes, active low |

## Verification
A corrupted interval counter shows up as a shift in the spacing of `busy_o` rising edges. Every refresh start is therefore timed against a multiple of four clocks from reset, and timed again across a soft reset. A wrong sequencer state or step count shows up in the same refresh as a CAS-to-RAS gap other than two, a RAS width other than the field plus one, or a hold that ends early. The bench compares the full strobe vector on every clock of every refresh across a sweep of bank patterns, pulse lengths and hold lengths. A lost or spurious pending request shows up within one or two clocks as a missing or unexpected `busy_o` edge.

// File: rtl/dref_pkg.sv
package dref_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAS,
    ST_RAS,
    ST_PRE,
    ST_SELF
  } seq_state_e;

  localparam int unsigned CAS_LEAD = 2;
endpackage

// File: rtl/dref_interval_ctr.sv
module dref_interval_ctr #(
  parameter int unsigned NB = 4,
  parameter int unsigned IW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NB-1:0] bank_en_i,
  input  logic [IW-1:0] intv_i,
  output logic          tick_o
);
  localparam int unsigned CW = IW + 2;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] thr;
  logic          run;

  assign run    = (|bank_en_i) && (|intv_i);
  assign thr    = {intv_i, 2'b00};
  // >= keeps the count bounded when the interval shrinks mid-count
  assign tick_o = run && (cnt_q >= thr - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run)   cnt_q <= cnt_q;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end

  a_r1_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> $stable(cnt_q));
  a_r2_wrap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> cnt_q == '0);
endmodule

// File: rtl/dref_pending.sv
module dref_pending (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic soft_rst_i,
  input  logic tick_i,
  input  logic force_i,
  input  logic take_i,
  output logic pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pend_o <= 1'b0;
    else if (soft_rst_i)        pend_o <= 1'b0;
    else if (tick_i || force_i) pend_o <= 1'b1;  // set wins over take
    else if (take_i)            pend_o <= 1'b0;
  end

  a_r10_keep_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((tick_i || force_i) && !soft_rst_i) |=> pend_o);
endmodule

// File: rtl/dref_wave_fsm.sv
module dref_wave_fsm
  import dref_pkg::*;
#(
  parameter int unsigned NB = 4,
  parameter int unsigned RW = 4,
  parameter int unsigned PW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_rst_i,
  input  logic          pend_i,
  input  logic          txn_busy_i,
  input  logic          sleep_req_i,
  input  logic [NB-1:0] bank_en_i,
  input  logic [RW-1:0] ras_len_i,
  input  logic [PW-1:0] pre_len_i,
  output logic          take_o,
  output logic [NB-1:0] cas_n_o,
  output logic [NB-1:0] ras_n_o,
  output logic          busy_o,
  output logic          hold_o,
  output logic          self_o
);
  localparam int unsigned SW = ((RW > PW) ? RW : PW) + 1;

  seq_state_e    st_q, st_d;
  logic [SW-1:0] step_q, step_d;
  logic [NB-1:0] mask_q, mask_d;
  logic [RW-1:0] rl_q, rl_d;
  logic [PW-1:0] pl_q, pl_d;
  logic          sleep_q, sleep_d;
  logic [NB-1:0] cas_n_d, ras_n_d;
  logic [SW-1:0] rl_ext, pl_ext;

  assign rl_ext = {{(SW-RW){1'b0}}, rl_q};
  assign pl_ext = {{(SW-PW){1'b0}}, pl_q};

  always_comb begin
    st_d    = st_q;
    step_d  = step_q + SW'(1);
    mask_d  = mask_q;
    rl_d    = rl_q;
    pl_d    = pl_q;
    sleep_d = sleep_q;
    take_o  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        step_d = '0;
        if (!txn_busy_i && (sleep_req_i || pend_i)) begin
          st_d    = ST_CAS;
          mask_d  = bank_en_i;
          rl_d    = ras_len_i;
          pl_d    = pre_len_i;
          sleep_d = sleep_req_i;
          take_o  = 1'b1;
        end
      end
      ST_CAS: if (step_q == SW'(CAS_LEAD - 1)) begin
        st_d   = ST_RAS;
        step_d = '0;
      end
      ST_RAS: if (step_q == rl_ext) begin
        step_d = '0;
        if (sleep_q)       st_d = ST_SELF;
        else if (pl_q == '0) st_d = ST_IDLE;
        else               st_d = ST_PRE;
      end
      ST_PRE: if (step_q == pl_ext - SW'(1)) begin
        st_d   = ST_IDLE;
        step_d = '0;
      end
      ST_SELF: step_d = '0;
      default: begin
        st_d   = ST_IDLE;
        step_d = '0;
      end
    endcase
    // self-refresh is left only through hardware reset
    if (soft_rst_i && st_q != ST_SELF) begin
      st_d    = ST_IDLE;
      step_d  = '0;
      sleep_d = 1'b0;
      take_o  = 1'b0;
    end
  end

  always_comb begin
    cas_n_d = (st_d == ST_CAS || st_d == ST_RAS || st_d == ST_SELF) ? '0 : '1;
    ras_n_d = (st_d == ST_RAS || st_d == ST_SELF) ? ~mask_d : '1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      step_q  <= '0;
      mask_q  <= '0;
      rl_q    <= '0;
      pl_q    <= '0;
      sleep_q <= 1'b0;
      cas_n_o <= '1;
      ras_n_o <= '1;
      busy_o  <= 1'b0;
      hold_o  <= 1'b0;
      self_o  <= 1'b0;
    end else begin
      st_q    <= st_d;
      step_q  <= step_d;
      mask_q  <= mask_d;
      rl_q    <= rl_d;
      pl_q    <= pl_d;
      sleep_q <= sleep_d;
      cas_n_o <= cas_n_d;
      ras_n_o <= ras_n_d;
      busy_o  <= (st_d != ST_IDLE);
      hold_o  <= (st_d == ST_PRE);
      self_o  <= (st_d == ST_SELF);
    end
  end

  a_r4_cas_before_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_n_o != '1) |-> (cas_n_o == '0));
  a_r4_ras_enabled_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~ras_n_o & ~mask_q) == '0);
  a_r4_two_clk_lead: assert property (@(posedge clk_i) disable iff (!rst_ni || soft_rst_i)
    $fell(cas_n_o[0]) |=> (ras_n_o == '1) ##1 (ras_n_o == ~mask_q));
  a_r5_release_together: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cas_n_o[0]) |-> (ras_n_o == '1));
  a_r6_hold_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> (cas_n_o == '1 && ras_n_o == '1 && busy_o));
  a_r9_self_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    self_o |=> (self_o && cas_n_o == '0));
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq #(
  parameter int unsigned NB = 4,
  parameter int unsigned IW = 8,
  parameter int unsigned RW = 4,
  parameter int unsigned PW = 4,
  localparam int unsigned BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          soft_rst_i,
  input  logic [NB-1:0] bank_en_i,
  input  logic [IW-1:0] intv_i,
  input  logic [RW-1:0] ras_len_i,
  input  logic [PW-1:0] pre_len_i,
  input  logic          txn_busy_i,
  input  logic          acc_req_i,
  input  logic [BW-1:0] acc_bank_i,
  input  logic          sleep_req_i,
  output logic          ref_due_o,
  output logic          busy_o,
  output logic          hold_o,
  output logic          self_ref_o,
  output logic [NB-1:0] cas_n_o,
  output logic [NB-1:0] ras_n_o
);
  logic tick, force_ref, take;

  assign force_ref = acc_req_i && !bank_en_i[acc_bank_i];

  dref_interval_ctr #(.NB(NB), .IW(IW)) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bank_en_i(bank_en_i),
    .intv_i   (intv_i),
    .tick_o   (tick)
  );

  dref_pending u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .soft_rst_i(soft_rst_i),
    .tick_i    (tick),
    .force_i   (force_ref),
    .take_i    (take),
    .pend_o    (ref_due_o)
  );

  dref_wave_fsm #(.NB(NB), .RW(RW), .PW(PW)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .pend_i     (ref_due_o),
    .txn_busy_i (txn_busy_i),
    .sleep_req_i(sleep_req_i),
    .bank_en_i  (bank_en_i),
    .ras_len_i  (ras_len_i),
    .pre_len_i  (pre_len_i),
    .take_o     (take),
    .cas_n_o    (cas_n_o),
    .ras_n_o    (ras_n_o),
    .busy_o     (busy_o),
    .hold_o     (hold_o),
    .self_o     (self_ref_o)
  );

  a_r3_wait_for_idle_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !$past(txn_busy_i));
  a_r8_enabled_access_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ref_due_o && !tick && acc_req_i && bank_en_i[acc_bank_i]) |=> !ref_due_o);
endmodule

// File: tb/dram_refresh_seq_tb_top.sv
`timescale 1ns/1ps
module dram_refresh_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       soft_rst_i = 1'b0;
  logic [3:0] bank_en_i = '0;
  logic [7:0] intv_i = '0;
  logic [3:0] ras_len_i = '0;
  logic [3:0] pre_len_i = '0;
  logic       txn_busy_i = 1'b0;
  logic       acc_req_i = 1'b0;
  logic [1:0] acc_bank_i = '0;
  logic       sleep_req_i = 1'b0;
  logic       ref_due_o, busy_o, hold_o, self_ref_o;
  logic [3:0] cas_n_o, ras_n_o;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dram_refresh_seq dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i),
    .bank_en_i(bank_en_i), .intv_i(intv_i), .ras_len_i(ras_len_i),
    .pre_len_i(pre_len_i), .txn_busy_i(txn_busy_i), .acc_req_i(acc_req_i),
    .acc_bank_i(acc_bank_i), .sleep_req_i(sleep_req_i),
    .ref_due_o(ref_due_o), .busy_o(busy_o), .hold_o(hold_o),
    .self_ref_o(self_ref_o), .cas_n_o(cas_n_o), .ras_n_o(ras_n_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
    summary();
  end

  function automatic int pack(input logic [3:0] c, input logic [3:0] r,
                              input logic b, input logic h);
    return int'({c, r, b, h});
  endfunction

  task automatic hw_reset(input logic [3:0] en, input logic [7:0] iv,
                          input logic [3:0] rl, input logic [3:0] pl);
    @(negedge clk);
    rst_ni = 1'b0;
    soft_rst_i = 1'b0; txn_busy_i = 1'b0; acc_req_i = 1'b0; sleep_req_i = 1'b0;
    bank_en_i = en; intv_i = iv; ras_len_i = rl; pre_len_i = pl;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic wait_busy_rise(output int t);
    logic prev;
    prev = busy_o;
    t = -1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (busy_o && !prev) begin t = cyc; break; end
      prev = busy_o;
    end
  endtask

  initial begin
    int t1, t2, t3, t0, gap;
    bit seen;

    // reset state
    hw_reset(4'h0, 8'd0, 4'd0, 4'd0);
    @(negedge clk);
    chk(cas_n_o == 4'hF && ras_n_o == 4'hF && !busy_o && !hold_o && !ref_due_o && !self_ref_o,
        "R1", "reset outputs", pack(cas_n_o, ras_n_o, busy_o, hold_o), pack(4'hF, 4'hF, 0, 0));

    // R1: counter stopped when interval is zero or no bank enabled
    hw_reset(4'hF, 8'd0, 4'd0, 4'd0);
    seen = 0;
    repeat (40) begin @(negedge clk); if (busy_o || ref_due_o) seen = 1; end
    chk(!seen, "R1", "refresh with intv=0", seen, 0);
    hw_reset(4'h0, 8'd3, 4'd0, 4'd0);
    seen = 0;
    repeat (40) begin @(negedge clk); if (busy_o || ref_due_o) seen = 1; end
    chk(!seen, "R1", "refresh with no bank", seen, 0);

    // R2: periodic spacing 4*intv, first start at 4*intv+1 after release
    for (int k = 1; k <= 6; k++) begin
      hw_reset(4'hF, 8'(k), 4'd0, 4'd0);
      t0 = cyc;
      wait_busy_rise(t1);
      wait_busy_rise(t2);
      wait_busy_rise(t3);
      chk(t1 - t0 == 4*k + 1, "R2", "first start after reset", t1 - t0, 4*k + 1);
      chk(t2 - t1 == 4*k, "R2", "interval 1", t2 - t1, 4*k);
      chk(t3 - t2 == 4*k, "R2", "interval 2", t3 - t2, 4*k);
    end

    // R4 R5 R6 R8: forced refresh waveform sweep
    for (int en = 0; en < 15; en++) begin
      for (int rl = 0; rl < 4; rl++) begin
        for (int pl = 0; pl < 4; pl++) begin
          int b;
          b = 0;
          for (int j = 3; j >= 0; j--) if (!en[j]) b = j;
          hw_reset(4'(en), 8'd0, 4'(rl), 4'(pl));
          @(negedge clk);
          acc_req_i = 1'b1; acc_bank_i = 2'(b);
          @(negedge clk);
          acc_req_i = 1'b0;
          chk(ref_due_o && cas_n_o == 4'hF && !busy_o, "R8", "pending after disabled access",
              pack(cas_n_o, ras_n_o, busy_o, ref_due_o), pack(4'hF, 4'hF, 0, 1));
          for (int i = 0; i <= 3 + rl + pl; i++) begin
            logic [3:0] ec, er;
            logic eb, eh;
            string tag;
            @(negedge clk);
            if (i < 2)           begin ec = 4'h0; er = 4'hF;       eb = 1; eh = 0; tag = "R4"; end
            else if (i < 3 + rl) begin ec = 4'h0; er = ~4'(en);    eb = 1; eh = 0; tag = "R5"; end
            else if (i < 3 + rl + pl) begin ec = 4'hF; er = 4'hF;  eb = 1; eh = 1; tag = "R6"; end
            else                 begin ec = 4'hF; er = 4'hF;       eb = 0; eh = 0; tag = "R6"; end
            chk(pack(cas_n_o, ras_n_o, busy_o, hold_o) == pack(ec, er, eb, eh), tag,
                $sformatf("en=%0h rl=%0d pl=%0d step=%0d", en, rl, pl, i),
                pack(cas_n_o, ras_n_o, busy_o, hold_o), pack(ec, er, eb, eh));
          end
        end
      end
    end

    // R8: access to an enabled bank does nothing
    hw_reset(4'b0101, 8'd0, 4'd0, 4'd0);
    @(negedge clk);
    acc_req_i = 1'b1; acc_bank_i = 2'd2;
    @(negedge clk);
    acc_req_i = 1'b0;
    seen = 0;
    repeat (6) begin if (busy_o || ref_due_o || cas_n_o != 4'hF) seen = 1; @(negedge clk); end
    chk(!seen, "R8", "enabled-bank access", seen, 0);

    // R3: wait for transaction end
    hw_reset(4'b0111, 8'd0, 4'd1, 4'd0);
    @(negedge clk);
    txn_busy_i = 1'b1;
    acc_req_i = 1'b1; acc_bank_i = 2'd3;
    @(negedge clk);
    acc_req_i = 1'b0;
    seen = 0;
    repeat (8) begin @(negedge clk); if (busy_o || cas_n_o != 4'hF) seen = 1; end
    chk(!seen && ref_due_o, "R3", "held while transaction busy", {seen, ref_due_o}, 1);
    txn_busy_i = 1'b0;
    @(negedge clk);
    chk(busy_o && cas_n_o == 4'h0 && !ref_due_o, "R3", "start after transaction",
        pack(cas_n_o, ras_n_o, busy_o, ref_due_o), pack(4'h0, 4'hF, 1, 0));

    // R10: requests during a long refresh are kept
    hw_reset(4'hF, 8'd1, 4'd7, 4'd0);
    wait_busy_rise(t1);
    gap = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!busy_o) begin
        chk(ref_due_o && cas_n_o == 4'hF, "R10", "pending at idle",
            pack(cas_n_o, ras_n_o, busy_o, ref_due_o), pack(4'hF, 4'hF, 0, 1));
        @(negedge clk);
        chk(busy_o && cas_n_o == 4'h0, "R10", "restart one clock later",
            pack(cas_n_o, ras_n_o, busy_o, hold_o), pack(4'h0, 4'hF, 1, 0));
        gap = 1;
        break;
      end
    end
    chk(gap == 1, "R10", "returned to idle", gap, 1);

    // R7: soft reset keeps counter phase
    hw_reset(4'hF, 8'd4, 4'd0, 4'd0);
    wait_busy_rise(t1);
    repeat (6) @(negedge clk);
    soft_rst_i = 1'b1;
    @(negedge clk);
    soft_rst_i = 1'b0;
    wait_busy_rise(t2);
    chk(t2 - t1 == 16, "R7", "interval across soft reset", t2 - t1, 16);
    // R7: soft reset aborts a refresh in progress
    ras_len_i = 4'd9;
    wait_busy_rise(t3);
    repeat (3) @(negedge clk);
    soft_rst_i = 1'b1;
    @(negedge clk);
    soft_rst_i = 1'b0;
    chk(!busy_o && cas_n_o == 4'hF && ras_n_o == 4'hF && !ref_due_o, "R7", "abort by soft reset",
        pack(cas_n_o, ras_n_o, busy_o, ref_due_o), pack(4'hF, 4'hF, 0, 0));

    // R9: self-refresh entry and hold
    hw_reset(4'b1011, 8'd0, 4'd2, 4'd1);
    @(negedge clk);
    sleep_req_i = 1'b1;
    @(negedge clk);
    chk(cas_n_o == 4'h0 && ras_n_o == 4'hF && busy_o, "R9", "entry cas first",
        pack(cas_n_o, ras_n_o, busy_o, 0), pack(4'h0, 4'hF, 1, 0));
    @(negedge clk);
    chk(ras_n_o == 4'hF, "R9", "entry ras still high", ras_n_o, 4'hF);
    @(negedge clk);
    chk(ras_n_o == 4'b0100 && cas_n_o == 4'h0, "R9", "entry ras on enabled",
        pack(cas_n_o, ras_n_o, 0, 0), pack(4'h0, 4'b0100, 0, 0));
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      acc_req_i = (i % 3 == 0);
      acc_bank_i = 2'd2;
      txn_busy_i = (i % 5 == 0);
      soft_rst_i = (i == 11);
      @(negedge clk);
      if (i > 3 && (cas_n_o != 4'h0 || ras_n_o != 4'b0100 || !self_ref_o)) seen = 1;
    end
    acc_req_i = 1'b0; txn_busy_i = 1'b0; soft_rst_i = 1'b0;
    chk(!seen, "R9", "strobes held in self-refresh", seen, 0);
    chk(self_ref_o && cas_n_o == 4'h0, "R9", "self flag", {self_ref_o, cas_n_o}, 5'h10);
    hw_reset(4'b1011, 8'd0, 4'd0, 4'd0);
    @(negedge clk);
    chk(!self_ref_o && cas_n_o == 4'hF && ras_n_o == 4'hF, "R9", "released by hard reset",
        pack(cas_n_o, ras_n_o, self_ref_o, 0), pack(4'hF, 4'hF, 0, 0));

    summary();
  end
endmodule